// File: doc/BRIEF.md
# Driver Command Serial Port

This block is the 16-bit serial slave port in front of a six-channel low-side gate-driver controller. A host drops chip select (active low), clocks command bits in and fault bits out, and raises chip select again. All three serial inputs pass through a two-flop synchronizer into the system clock. Command bits are sampled on serial clock rising edges and fault bits are shifted out on falling edges, most significant bit first in both directions.

A window counts as valid only if its serial clock count is a non-zero whole multiple of 16. When a valid window closes, the last 16 bits received are decoded into a write to one of four 6-bit control registers, and the fault store is reloaded from the current fault inputs. When a window is malformed, the command is dropped and the stored fault word stays available for the next read. A fault flag is cleared when chip select falls and is armed again when chip select rises.

Top module: `drvspi_top`

## Requirements
- R1: The first 16 bits driven on the serial output in a window are the fault word that was stored when chip select fell, MSB first. Bits 15:12 are zero and channel n's 2-bit code sits in bits 2n+1:2n, so channel 5 is in bits 11:10 and channel 0 is in bits 1:0.
- R2: A window is valid only when its serial clock count is a non-zero multiple of 16. Only the last 16 bits received in a valid window are decoded.
- R3: In a decoded word with bit 15 = 0 and bit 14 = 0, bits 13:12 select the register (00 gate select, 01 disable mode, 10 refresh/reference, 11 flag mask) and bits 5:0 are written into it. Bits 11:6 are ignored.
- R4: A decoded word with bit 15 = 1, or with bit 14 = 1 (null access), writes no register.
- R5: When a window is malformed, no register changes and the stored fault word is kept for the next read.
- R6: At the end of a valid window, the stored fault word is replaced by the current fault inputs.
- R7: While chip select is high, a channel whose stored code is 00 takes the channel's current non-zero code, and a non-zero stored code is held. While chip select is low, the stored word does not change.
- R8: The fault flag is low from chip select falling until it rises. Outside a window, the flag is high exactly when the stored fault word is non-zero.
- R9: Writes to the gate-select register are dropped while the master enable is low. The other three registers can still be written.
- R10: After reset, all four registers are zero, the stored fault word is zero and the flag is low.
- R11: The serial output enable is high only while the synchronized chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Serial command data in |
| spi_miso_o | output | 1 | Serial fault data out |
| spi_miso_oe_o | output | 1 | Output enable for the serial data pad |
| en_main_i | input | 1 | Master enable; gate-select writes need it high |
| fault_now_i | input | 12 | Current 2-bit fault code per channel |
| gate_sel_o | output | 6 | Gate select register |
| dis_mode_o | output | 6 | Disable mode register |
| refref_o | output | 6 | Refresh/reference register |
| flag_mask_o | output | 6 | Flag mask register |
| fault_flag_o | output | 1 | Fault flag, high when armed and a fault is stored |

## Verification
Windows of exactly 16 and 32 clocks are mixed with windows of random length (0 to 39 clocks). This separates correct multiple-of-16 framing from off-by-one counting, and shows whether the port decodes the last word or the first. The command words are random, and most of them have bit 15 clear, so every address, the null space and the bit-15 rejection all occur. The master enable is toggled at random, which separates gate-select gating from the other registers. Fault inputs change between windows, and directed sequences around a malformed window show whether the stored word survives an error and whether sticky capture differs from a plain copy.

// File: rtl/drvspi_pkg.sv
package drvspi_pkg;
  typedef enum logic [1:0] {
    REG_GATE  = 2'd0,
    REG_DMODE = 2'd1,
    REG_RFREF = 2'd2,
    REG_FMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/drvspi_sync.sv
module drvspi_sync #(
  parameter int unsigned       WIDTH   = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/drvspi_frame.sv
module drvspi_frame #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned FAULT_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_s_i,
  input  logic               sclk_s_i,
  input  logic               mosi_s_i,
  input  logic [FAULT_W-1:0] tx_load_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic               csn_fall_o,
  output logic               done_o,
  output logic               valid_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned PAD_W = WORD_W - FAULT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);

  logic              csn_d_q, sclk_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              seen_q, seen_d;
  logic [WORD_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic              csn_fall, csn_rise, sclk_rise, sclk_fall;

  assign csn_fall  = csn_d_q & ~csn_s_i;
  assign csn_rise  = ~csn_d_q & csn_s_i;
  assign sclk_rise = ~sclk_d_q & sclk_s_i & ~csn_s_i;
  assign sclk_fall = sclk_d_q & ~sclk_s_i & ~csn_s_i;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    if (csn_fall) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      tx_d   = {{PAD_W{1'b0}}, tx_load_i};
    end else begin
      if (sclk_rise) begin
        rx_d = {rx_q[WORD_W-2:0], mosi_s_i};
        if (cnt_q == CNT_MAX) begin
          cnt_d  = '0;
          seen_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (sclk_fall) tx_d = {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d_q  <= 1'b1;
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
    end else begin
      csn_d_q  <= csn_s_i;
      sclk_d_q <= sclk_s_i;
      cnt_q    <= cnt_d;
      seen_q   <= seen_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
    end
  end

  assign miso_o     = tx_q[WORD_W-1];
  assign miso_oe_o  = ~csn_s_i;
  assign csn_fall_o = csn_fall;
  assign done_o     = csn_rise;
  assign valid_o    = seen_q & (cnt_q == '0);
  assign word_o     = rx_q;
endmodule

// File: rtl/drvspi_regs.sv
module drvspi_regs
  import drvspi_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DATA_W = 6,
  parameter int unsigned NREG   = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        done_i,
  input  logic                        valid_i,
  input  logic                        en_main_i,
  input  logic [WORD_W-1:0]           word_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  localparam int unsigned SEL_W = $clog2(NREG);

  logic [SEL_W:0]  addr;
  logic            wr_ok;
  logic [NREG-1:0] we;
  logic            unused_bits;

  assign addr        = word_i[WORD_W-2 -: SEL_W+1];
  assign wr_ok       = done_i & valid_i & ~word_i[WORD_W-1] & ~addr[SEL_W];
  assign unused_bits = ^word_i[WORD_W-SEL_W-3:DATA_W];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(REG_GATE)) begin : g_gated
      assign we[g] = wr_ok & (addr[SEL_W-1:0] == SEL_W'(g)) & en_main_i;
    end else begin : g_plain
      assign we[g] = wr_ok & (addr[SEL_W-1:0] == SEL_W'(g));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    regs_o[g] <= '0;
      else if (we[g]) regs_o[g] <= word_i[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/drvspi_fault.sv
module drvspi_fault #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CODE_W = 2,
  localparam int unsigned FAULT_W = NUM_CH * CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_fall_i,
  input  logic               done_i,
  input  logic               valid_i,
  input  logic               in_frame_i,
  input  logic [FAULT_W-1:0] fault_now_i,
  output logic [FAULT_W-1:0] latch_o,
  output logic               flag_o
);
  logic [FAULT_W-1:0] latch_q, latch_d;
  logic               armed_q, armed_d;

  always_comb begin
    latch_d = latch_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (done_i && valid_i) begin
        latch_d[ch*CODE_W +: CODE_W] = fault_now_i[ch*CODE_W +: CODE_W];
      end else if (!in_frame_i && (latch_q[ch*CODE_W +: CODE_W] == '0)) begin
        latch_d[ch*CODE_W +: CODE_W] = fault_now_i[ch*CODE_W +: CODE_W];
      end
    end
    armed_d = armed_q;
    if (csn_fall_i)  armed_d = 1'b0;
    else if (done_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      armed_q <= 1'b1;
    end else begin
      latch_q <= latch_d;
      armed_q <= armed_d;
    end
  end

  assign latch_o = latch_q;
  assign flag_o  = armed_q & (|latch_q);
endmodule

// File: rtl/drvspi_top.sv
module drvspi_top
  import drvspi_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned CODE_W      = 2,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned DATA_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       spi_sclk_i,
  input  logic                       spi_csn_i,
  input  logic                       spi_mosi_i,
  output logic                       spi_miso_o,
  output logic                       spi_miso_oe_o,
  input  logic                       en_main_i,
  input  logic [NUM_CH*CODE_W-1:0]   fault_now_i,
  output logic [DATA_W-1:0]          gate_sel_o,
  output logic [DATA_W-1:0]          dis_mode_o,
  output logic [DATA_W-1:0]          refref_o,
  output logic [DATA_W-1:0]          flag_mask_o,
  output logic                       fault_flag_o
);
  localparam int unsigned FAULT_W = NUM_CH * CODE_W;
  localparam int unsigned NREG    = 4;

  logic [2:0]              pins_s;
  logic                    frm_done, frm_valid, frm_csn_fall;
  logic [WORD_W-1:0]       frm_word;
  logic [FAULT_W-1:0]      fault_latch;
  logic [NREG-1:0][DATA_W-1:0] regs;

  drvspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_csn_i, spi_sclk_i, spi_mosi_i}),
    .q_o   (pins_s)
  );

  drvspi_frame #(.WORD_W(WORD_W), .FAULT_W(FAULT_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_s_i   (pins_s[2]),
    .sclk_s_i  (pins_s[1]),
    .mosi_s_i  (pins_s[0]),
    .tx_load_i (fault_latch),
    .miso_o    (spi_miso_o),
    .miso_oe_o (spi_miso_oe_o),
    .csn_fall_o(frm_csn_fall),
    .done_o    (frm_done),
    .valid_o   (frm_valid),
    .word_o    (frm_word)
  );

  drvspi_regs #(.WORD_W(WORD_W), .DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (frm_done),
    .valid_i  (frm_valid),
    .en_main_i(en_main_i),
    .word_i   (frm_word),
    .regs_o   (regs)
  );

  drvspi_fault #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_fall_i (frm_csn_fall),
    .done_i     (frm_done),
    .valid_i    (frm_valid),
    .in_frame_i (~pins_s[2]),
    .fault_now_i(fault_now_i),
    .latch_o    (fault_latch),
    .flag_o     (fault_flag_o)
  );

  assign gate_sel_o  = regs[REG_GATE];
  assign dis_mode_o  = regs[REG_DMODE];
  assign refref_o    = regs[REG_RFREF];
  assign flag_mask_o = regs[REG_FMASK];
endmodule

// File: rtl/drvspi_chk.sv
module drvspi_chk #(
  parameter int unsigned DATA_W  = 6,
  parameter int unsigned FAULT_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               oe_i,
  input logic               flag_i,
  input logic               en_main_i,
  input logic               done_i,
  input logic               valid_i,
  input logic [FAULT_W-1:0] latch_i,
  input logic [DATA_W-1:0]  gate_i,
  input logic [DATA_W-1:0]  dmode_i,
  input logic [DATA_W-1:0]  rfref_i,
  input logic [DATA_W-1:0]  fmask_i
);
  AST_FLAG_OFF_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i)) |-> !flag_i); // R8

  AST_GATE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_i) |-> $past(en_main_i)); // R9

  AST_NO_WRITE_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !valid_i) |=> ($stable(gate_i) && $stable(dmode_i) && $stable(rfref_i) && $stable(fmask_i))); // R5

  AST_WRITE_AT_VALID_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dmode_i) || !$stable(rfref_i) || !$stable(fmask_i)) |-> $past(done_i && valid_i)); // R2

  AST_LATCH_HOLD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oe_i) |-> $stable(latch_i)); // R7
endmodule

bind drvspi_top drvspi_chk #(.DATA_W(DATA_W), .FAULT_W(NUM_CH*CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .oe_i     (spi_miso_oe_o),
  .flag_i   (fault_flag_o),
  .en_main_i(en_main_i),
  .done_i   (frm_done),
  .valid_i  (frm_valid),
  .latch_i  (fault_latch),
  .gate_i   (gate_sel_o),
  .dmode_i  (dis_mode_o),
  .rfref_i  (refref_o),
  .fmask_i  (flag_mask_o)
);

// File: tb/drvspi_top_tb_top.sv
module drvspi_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sclk, csn, mosi, en_main;
  logic        miso, miso_oe, flag;
  logic [11:0] fnow;
  logic [5:0]  gate, dmode, rfref, fmask;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [5:0]  m_regs [4];
  logic [11:0] m_lat;

  drvspi_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .en_main_i(en_main), .fault_now_i(fnow), .gate_sel_o(gate),
    .dis_mode_o(dmode), .refref_o(rfref), .flag_mask_o(fmask),
    .fault_flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sticky(input logic [11:0] lat, input logic [11:0] now);
    logic [11:0] r = lat;
    for (int c = 0; c < 6; c++)
      if (lat[2*c +: 2] == 2'b00) r[2*c +: 2] = now[2*c +: 2];
    return r;
  endfunction

  task automatic check_regs(input string req);
    chk(gate  == m_regs[0], req, 32'(gate),  32'(m_regs[0]));
    chk(dmode == m_regs[1], req, 32'(dmode), 32'(m_regs[1]));
    chk(rfref == m_regs[2], req, 32'(rfref), 32'(m_regs[2]));
    chk(fmask == m_regs[3], req, 32'(fmask), 32'(m_regs[3]));
  endtask

  task automatic set_fault(input logic [11:0] v);
    @(negedge clk) fnow = v;
    repeat (4) @(negedge clk);
    m_lat = sticky(m_lat, v);
  endtask

  task automatic frame(input logic [63:0] data, input int nbits, input string req);
    logic [15:0] so_word = '0;
    logic [15:0] so_exp  = {4'b0000, m_lat};
    logic [15:0] w;
    bit valid;
    @(negedge clk) csn = 1'b0;
    repeat (6) @(negedge clk);
    chk(flag == 1'b0, "R8", 32'(flag), 32'd0);
    chk(miso_oe == 1'b1, "R11", 32'(miso_oe), 32'd1);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = data[i];
      repeat (6) @(negedge clk);
      if (nbits - 1 - i < 16) so_word[15 - (nbits - 1 - i)] = miso;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
    if (nbits >= 16) chk(so_word == so_exp, "R1", 32'(so_word), 32'(so_exp));
    valid = (nbits > 0) && (nbits % 16 == 0);
    w = data[15:0];
    if (valid) begin
      if (!w[15] && !w[14] && (w[13:12] != 2'b00 || en_main)) m_regs[w[13:12]] = w[5:0];
      m_lat = fnow;
    end
    m_lat = sticky(m_lat, fnow);
    check_regs(req);
    chk(flag == (|m_lat), "R8", 32'(flag), 32'(|m_lat));
    chk(miso_oe == 1'b0, "R11", 32'(miso_oe), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0; en_main = 1'b1; fnow = '0;
    for (int r = 0; r < 4; r++) m_regs[r] = '0;
    m_lat = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check_regs("R10");
    chk(flag == 1'b0, "R10", 32'(flag), 32'd0);
    chk(miso_oe == 1'b0, "R11", 32'(miso_oe), 32'd0);

    // R3 one write per register, upper data bits ignored
    frame(64'h0FC5, 16, "R3");
    frame(64'h1F2A, 16, "R3");
    frame(64'h2033, 16, "R3");
    frame(64'h3E1C, 16, "R3");

    // R9 gate write ignored with enable low, others still written
    en_main = 1'b0;
    frame(64'h0012, 16, "R9");
    frame(64'h1007, 16, "R9");
    chk(gate == 6'h05, "R9", 32'(gate), 32'h05);
    chk(dmode == 6'h07, "R9", 32'(dmode), 32'h07);
    en_main = 1'b1;

    // R4 bit 15 set and null space
    frame(64'hB03F, 16, "R4");
    frame(64'h4021, 16, "R4");
    frame(64'h7FFF, 16, "R4");

    // R5 and R2 malformed windows
    frame(64'h1011, 15, "R5");
    frame(64'h2_1011, 17, "R5");
    frame(64'h0, 0, "R2");
    // R2 two words, the last one wins
    frame({32'h0, 16'h3001, 16'h2009}, 32, "R2");
    chk(rfref == 6'h09, "R2", 32'(rfref), 32'h09);

    // R6 R7 fault store and kept data after an error
    set_fault(12'b01_00_10_00_11_00);
    frame(64'h4000, 16, "R7");
    set_fault(12'b00_11_01_00_00_10);
    frame(64'h1_4000, 17, "R5");
    frame(64'h4000, 16, "R6");
    set_fault(12'h000);
    frame(64'h4000, 16, "R6");
    frame(64'h4000, 16, "R6");
    chk(flag == 1'b0, "R8", 32'(flag), 32'd0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [63:0] d;
      int nb;
      int sel;
      d = {$urandom, $urandom};
      if ($urandom % 4 != 0) d[15] = 1'b0;
      sel = int'($urandom % 4);
      nb = (sel == 1) ? 32 : (sel == 2) ? int'($urandom % 40) : 16;
      en_main = ($urandom % 4 != 0);
      if ($urandom % 2 == 0) set_fault(12'($urandom));
      frame(d, nb, (nb > 0 && nb % 16 == 0) ? "R3" : "R5");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule